// File: doc/BRIEF.md
# Encoder Position Compare Unit

This block watches the live position of a quadrature encoder and reports when it reaches a programmed target. The position arrives as a revolution count and a phase count within the revolution, together with the current rotation direction. The block compares them against a target revolution, a target phase and a wanted direction. It raises a sticky match flag and a single-cycle event pulse when the match condition first becomes true.

Phase equality is always part of the match. Revolution equality and direction qualification are each optional, and a control bit leaves each one out. Software clears the sticky flag with a write-one-to-clear strobe. Four enable bits route the result to the rest of the chip. The interrupt follows the flag as a level. The DMA request, the trigger output and the counter-capture strobe each follow the event pulse for one cycle.

Top module: `pos_cmp_unit`

## Requirements
- R1: While reset is asserted and directly after it, the flag, the pulse and all four qualified outputs are 0.
- R2: Phase equality is always required. A phase count that differs from the phase target gives no match, whatever the other inputs and ignore bits are.
- R3: With `rev_ign_i`=0 the revolution count must equal the revolution target. With `rev_ign_i`=1 the revolution count does not affect the match.
- R4: With `dir_ign_i`=1 the rotation direction does not affect the match.
- R5: With `dir_ign_i`=0, `dir_cmp_i`=0 matches only while `dir_i`=0 (positive rotation), and `dir_cmp_i`=1 matches only while `dir_i`=1 (negative rotation).
- R6: The clock edge that first samples a true match condition sets `match_flag_o` and raises `match_pulse_o`. Both are visible right after that edge, and the pulse lasts exactly one cycle.
- R7: While the condition stays true, no further pulse is produced. The flag stays set until it is cleared.
- R8: A clock edge that samples `flag_clr_i`=1 clears the flag, provided no new match starts on that edge.
- R9: When a new match starts on the same edge that samples `flag_clr_i`=1, the flag stays set and the pulse is produced.
- R10: `irq_o` equals `match_flag_o` while `irq_en_i`=1 and is 0 while `irq_en_i`=0.
- R11: `dma_req_o`, `trig_o` and `cap_o` each equal `match_pulse_o` gated by `dma_en_i`, `trig_en_i` and `cap_en_i` respectively.
- R12: Clearing the flag while the condition is still true does not set it again. A new match needs the condition to go false and then true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rev_cnt_i | input | 32 | Current revolution count |
| phase_cnt_i | input | 21 | Current phase count |
| dir_i | input | 1 | Rotation direction: 0 positive, 1 negative |
| rev_cmp_i | input | 32 | Revolution target |
| phase_cmp_i | input | 21 | Phase target |
| dir_cmp_i | input | 1 | Wanted direction: 0 positive, 1 negative |
| rev_ign_i | input | 1 | 1 leaves the revolution count out of the match |
| dir_ign_i | input | 1 | 1 leaves the direction out of the match |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| irq_en_i | input | 1 | Interrupt enable |
| dma_en_i | input | 1 | DMA request enable |
| trig_en_i | input | 1 | Trigger output enable |
| cap_en_i | input | 1 | Counter capture enable |
| match_flag_o | output | 1 | Sticky match flag |
| match_pulse_o | output | 1 | One-cycle match event |
| irq_o | output | 1 | Interrupt request (level) |
| dma_req_o | output | 1 | DMA request (one cycle) |
| trig_o | output | 1 | Trigger output (one cycle) |
| cap_o | output | 1 | Counter capture strobe (one cycle) |

## Verification
A stuck or missing condition-history bit shows up one cycle after a match. The pulse either repeats or never reappears, and after a clear the flag sets again while the target is held. A wrong term in the comparator appears on the edge right after the stimulus: the flag either rises on a mismatch or stays low on a match. A wrong priority between set and clear shows as a flag that is low right after the combined edge. The directed sequences sample every output one edge after each input change, so each of these faults is caught within one clock.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int unsigned REV_W_DEF = 32;
  localparam int unsigned PH_W_DEF  = 21;
  localparam int unsigned N_EVT     = 4;

  typedef enum logic {
    DIR_POS = 1'b0,
    DIR_NEG = 1'b1
  } rot_dir_e;

  // channel order on the qualified output vector
  localparam int unsigned EVT_IRQ  = 0;
  localparam int unsigned EVT_DMA  = 1;
  localparam int unsigned EVT_TRIG = 2;
  localparam int unsigned EVT_CAP  = 3;

  // 1 = channel follows the sticky flag, 0 = channel follows the pulse
  localparam logic [N_EVT-1:0] EVT_LEVEL = 4'b0001;
endpackage

// File: rtl/pos_match.sv
module pos_match
  import qpc_pkg::*;
#(
  parameter int unsigned REV_W = REV_W_DEF,
  parameter int unsigned PH_W  = PH_W_DEF
) (
  input  logic [REV_W-1:0] rev_cnt_i,
  input  logic [PH_W-1:0]  phase_cnt_i,
  input  rot_dir_e         dir_i,
  input  logic [REV_W-1:0] rev_cmp_i,
  input  logic [PH_W-1:0]  phase_cmp_i,
  input  rot_dir_e         dir_cmp_i,
  input  logic             rev_ign_i,
  input  logic             dir_ign_i,
  output logic             hit_o
);
  logic ph_eq, rev_ok, dir_ok;

  always_comb begin
    ph_eq  = (phase_cnt_i == phase_cmp_i);
    rev_ok = rev_ign_i | (rev_cnt_i == rev_cmp_i);
    dir_ok = dir_ign_i | (dir_i == dir_cmp_i);
    hit_o  = ph_eq & rev_ok & dir_ok;
  end
endmodule

// File: rtl/pos_flag.sv
module pos_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pulse_o
);
  logic hit_q;
  logic rise;

  assign rise = hit_i & ~hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      pulse_o <= 1'b0;
      flag_o  <= 1'b0;
    end else begin
      hit_q   <= hit_i;
      pulse_o <= rise;
      // set has priority over a same-cycle clear
      if (rise)       flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_gate.sv
module evt_gate
  import qpc_pkg::*;
#(
  parameter int unsigned       N     = N_EVT,
  parameter logic [N-1:0]      LEVEL = EVT_LEVEL
) (
  input  logic         flag_i,
  input  logic         pulse_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] evt_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    if (LEVEL[g]) begin : g_lvl
      assign evt_o[g] = en_i[g] & flag_i;
    end else begin : g_pls
      assign evt_o[g] = en_i[g] & pulse_i;
    end
  end
endmodule

// File: rtl/pos_cmp_unit.sv
module pos_cmp_unit
  import qpc_pkg::*;
#(
  parameter int unsigned REV_W = REV_W_DEF,
  parameter int unsigned PH_W  = PH_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REV_W-1:0] rev_cnt_i,
  input  logic [PH_W-1:0]  phase_cnt_i,
  input  logic             dir_i,
  input  logic [REV_W-1:0] rev_cmp_i,
  input  logic [PH_W-1:0]  phase_cmp_i,
  input  logic             dir_cmp_i,
  input  logic             rev_ign_i,
  input  logic             dir_ign_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  input  logic             dma_en_i,
  input  logic             trig_en_i,
  input  logic             cap_en_i,
  output logic             match_flag_o,
  output logic             match_pulse_o,
  output logic             irq_o,
  output logic             dma_req_o,
  output logic             trig_o,
  output logic             cap_o
);
  logic             hit;
  logic [N_EVT-1:0] en_vec, evt_vec;

  pos_match #(.REV_W(REV_W), .PH_W(PH_W)) u_match (
    .rev_cnt_i   (rev_cnt_i),
    .phase_cnt_i (phase_cnt_i),
    .dir_i       (rot_dir_e'(dir_i)),
    .rev_cmp_i   (rev_cmp_i),
    .phase_cmp_i (phase_cmp_i),
    .dir_cmp_i   (rot_dir_e'(dir_cmp_i)),
    .rev_ign_i   (rev_ign_i),
    .dir_ign_i   (dir_ign_i),
    .hit_o       (hit)
  );

  pos_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .clr_i   (flag_clr_i),
    .flag_o  (match_flag_o),
    .pulse_o (match_pulse_o)
  );

  always_comb begin
    en_vec           = '0;
    en_vec[EVT_IRQ]  = irq_en_i;
    en_vec[EVT_DMA]  = dma_en_i;
    en_vec[EVT_TRIG] = trig_en_i;
    en_vec[EVT_CAP]  = cap_en_i;
  end

  evt_gate #(.N(N_EVT), .LEVEL(EVT_LEVEL)) u_gate (
    .flag_i  (match_flag_o),
    .pulse_i (match_pulse_o),
    .en_i    (en_vec),
    .evt_o   (evt_vec)
  );

  assign irq_o     = evt_vec[EVT_IRQ];
  assign dma_req_o = evt_vec[EVT_DMA];
  assign trig_o    = evt_vec[EVT_TRIG];
  assign cap_o     = evt_vec[EVT_CAP];
endmodule

// File: rtl/pos_cmp_unit_chk.sv
module pos_cmp_unit_chk #(
  parameter int unsigned PH_W = 21
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PH_W-1:0] phase_cnt_i,
  input logic [PH_W-1:0] phase_cmp_i,
  input logic            flag_clr_i,
  input logic            irq_en_i,
  input logic            match_flag_o,
  input logic            match_pulse_o,
  input logic            irq_o,
  input logic            dma_req_o,
  input logic            trig_o,
  input logic            cap_o
);
  a_r2_phase_eq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_pulse_o) |-> $past(phase_cnt_i == phase_cmp_i));

  a_r6_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_pulse_o |=> !match_pulse_o);

  a_r6_pulse_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_pulse_o |-> match_flag_o);

  a_r6_rise_has_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_flag_o) |-> match_pulse_o);

  a_r7_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_flag_o && !flag_clr_i) |=> match_flag_o);

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_flag_o && flag_clr_i) |=> (!match_flag_o || match_pulse_o));

  a_r10_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (match_flag_o && irq_en_i));

  a_r11_evt_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o || trig_o || cap_o) |-> match_pulse_o);
endmodule

bind pos_cmp_unit pos_cmp_unit_chk #(.PH_W(PH_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .phase_cnt_i   (phase_cnt_i),
  .phase_cmp_i   (phase_cmp_i),
  .flag_clr_i    (flag_clr_i),
  .irq_en_i      (irq_en_i),
  .match_flag_o  (match_flag_o),
  .match_pulse_o (match_pulse_o),
  .irq_o         (irq_o),
  .dma_req_o     (dma_req_o),
  .trig_o        (trig_o),
  .cap_o         (cap_o)
);

// File: tb/pos_cmp_unit_test.sv
`timescale 1ns/1ps
module pos_cmp_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] rev_cnt_i = 32'd5, rev_cmp_i = 32'd5;
  logic [20:0] phase_cnt_i = 21'd99, phase_cmp_i = 21'd100;
  logic        dir_i = 1'b0, dir_cmp_i = 1'b0;
  logic        rev_ign_i = 1'b0, dir_ign_i = 1'b0, flag_clr_i = 1'b0;
  logic        irq_en_i = 1'b1, dma_en_i = 1'b1, trig_en_i = 1'b0, cap_en_i = 1'b1;
  logic        match_flag_o, match_pulse_o, irq_o, dma_req_o, trig_o, cap_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pos_cmp_unit uut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    tick();
    flag_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flag in reset", match_flag_o, 1'b0);
    chk("R1 pulse in reset", match_pulse_o, 1'b0);
    chk("R1 irq in reset", irq_o, 1'b0);
    rst_ni = 1'b1;
    tick();
    chk("R1 flag after reset", match_flag_o, 1'b0);
    chk("R1 dma after reset", dma_req_o, 1'b0);
    chk("R1 cap after reset", cap_o, 1'b0);
  endtask

  task automatic t_phase_mismatch();
    phase_cnt_i = 21'd99;
    tick(); tick();
    chk("R2 phase mismatch flag", match_flag_o, 1'b0);
    chk("R2 phase mismatch pulse", match_pulse_o, 1'b0);
  endtask

  task automatic t_basic_match();
    phase_cnt_i = 21'd100;
    tick();
    chk("R6 flag set", match_flag_o, 1'b1);
    chk("R6 pulse set", match_pulse_o, 1'b1);
    chk("R11 dma with pulse", dma_req_o, 1'b1);
    chk("R11 trig disabled", trig_o, 1'b0);
    chk("R11 cap with pulse", cap_o, 1'b1);
    chk("R10 irq with flag", irq_o, 1'b1);
    tick();
    chk("R6 pulse one cycle", match_pulse_o, 1'b0);
    chk("R7 flag held", match_flag_o, 1'b1);
    chk("R11 dma after pulse", dma_req_o, 1'b0);
    chk("R10 irq level", irq_o, 1'b1);
    tick();
    chk("R7 no repeat pulse", match_pulse_o, 1'b0);
  endtask

  task automatic t_clear_held();
    clear_flag();
    chk("R8 flag cleared", match_flag_o, 1'b0);
    chk("R10 irq follows clear", irq_o, 1'b0);
    tick();
    chk("R12 no reset while held", match_flag_o, 1'b0);
    chk("R12 no pulse while held", match_pulse_o, 1'b0);
    phase_cnt_i = 21'd99;
    tick();
  endtask

  task automatic t_rev();
    rev_cnt_i = 32'd6;
    phase_cnt_i = 21'd100;
    tick();
    chk("R3 rev mismatch blocks", match_flag_o, 1'b0);
    rev_ign_i = 1'b1;
    tick();
    chk("R3 rev ignored flag", match_flag_o, 1'b1);
    chk("R3 rev ignored pulse", match_pulse_o, 1'b1);
    phase_cnt_i = 21'd99;
    clear_flag();
    chk("R8 clear after rev", match_flag_o, 1'b0);
    rev_ign_i = 1'b0;
    rev_cnt_i = 32'd5;
    tick();
  endtask

  task automatic t_dir();
    dir_i = 1'b1;
    phase_cnt_i = 21'd100;
    tick();
    chk("R5 cmp0 rejects negative", match_flag_o, 1'b0);
    dir_cmp_i = 1'b1;
    tick();
    chk("R5 cmp1 accepts negative", match_flag_o, 1'b1);
    phase_cnt_i = 21'd99;
    clear_flag();
    dir_i = 1'b0;
    phase_cnt_i = 21'd100;
    tick();
    chk("R5 cmp1 rejects positive", match_flag_o, 1'b0);
    dir_ign_i = 1'b1;
    tick();
    chk("R4 dir ignored flag", match_flag_o, 1'b1);
    chk("R4 dir ignored pulse", match_pulse_o, 1'b1);
  endtask

  task automatic t_set_wins();
    phase_cnt_i = 21'd99;
    tick();
    chk("R7 flag held off target", match_flag_o, 1'b1);
    trig_en_i = 1'b1; dma_en_i = 1'b0; cap_en_i = 1'b0;
    phase_cnt_i = 21'd100;
    flag_clr_i = 1'b1;
    tick();
    flag_clr_i = 1'b0;
    chk("R9 set beats clear flag", match_flag_o, 1'b1);
    chk("R9 set beats clear pulse", match_pulse_o, 1'b1);
    chk("R11 trig with pulse", trig_o, 1'b1);
    chk("R11 dma disabled", dma_req_o, 1'b0);
    chk("R11 cap disabled", cap_o, 1'b0);
    irq_en_i = 1'b0;
    #1;
    chk("R10 irq disabled", irq_o, 1'b0);
  endtask

  task automatic t_phase_with_ignores();
    phase_cnt_i = 21'd101;
    rev_ign_i = 1'b1;
    clear_flag();
    tick(); tick();
    chk("R2 mismatch with ignores", match_flag_o, 1'b0);
    chk("R2 no pulse with ignores", match_pulse_o, 1'b0);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_phase_mismatch();
    t_basic_match();
    t_clear_held();
    t_rev();
    t_dir();
    t_set_wins();
    t_phase_with_ignores();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule